// File: doc/BRIEF.md
# Calendar Clock with Update-in-Progress Flag

This block keeps calendar time in BCD across seven fields: seconds, minutes, hours, day of month, month, two-digit year and century. A host reaches every field through a two-address byte bus. It writes a register number at address 0, then reads or writes that register at address 1. A free-running prescaler divides the system clock into step enables and counts a fixed number of steps per second.

On each second boundary the block raises an update-in-progress flag. It leaves every field untouched for a guard interval. It then walks a carry ripple that advances one field per step enable, starting at seconds. The ripple stops at the first field that does not wrap, and the flag drops in that same step.

Because the ripple is spread over several steps, a read taken mid-update can return a mix of old and new fields. Software avoids this by polling the flag. It can instead enable a flag that goes high each time an update finishes.

Top module: `rtc_uip_clock`

## Requirements
- R1: After reset the time reads 2000-01-01 00:00:00. That is century 0x20, year 0x00, month 0x01, day 0x01 and hours, minutes and seconds 0x00. The update flag, the interrupt enable, the interrupt flag and `irq_o` are all 0, and the register number is 0x00.
- R2: A write at `bus_addr`=0 stores the register number, and `bus_rdata` returns it while `bus_addr`=0. At `bus_addr`=1 the selected register is read and written. The time registers are 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day, 0x04 month, 0x05 year and 0x06 century. An unmapped number reads 0x00. Outside an update, time changes only through host writes.
- R3: An update starts once every `STEPS_PER_SEC` step enables, where a step enable occurs every `CLKS_PER_STEP` clock cycles. The flag, read as bit 7 of register 0x0A, rises on a step enable.
- R4: For `GUARD_STEPS` step enables after the flag rises, no time field changes.
- R5: After the guard, each step enable advances exactly one field, in the order seconds, minutes, hours, day, month, year, century. The ripple moves to the next field only when the current one wraps. The flag clears on the step that advances the first non-wrapping field, so the flag stays high for (`GUARD_STEPS` + fields advanced) step enables.
- R6: Partially updated time is readable while the ripple is under way. For example, seconds reads 0x00 while minutes still reads 0x59.
- R7: Seconds and minutes wrap from 59 to 00 and hours from 23 to 00. Month wraps from 12 to 01. Year wraps from 99 to 00 and carries into century.
- R8: The day wraps to 01 after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11. In February it wraps after day 29 in a leap year and after day 28 otherwise. A leap year is a year divisible by 4, except that year 00 is a leap year only when the century is divisible by 4.
- R9: Writes to time registers are dropped while the update flag is set.
- R10: When bit 0 of register 0x0B is 1, the interrupt flag (bit 0 of register 0x0C, driven on `irq_o`) sets in the cycle the update flag clears. Any write to register 0x0C clears it. When bit 0 of register 0x0B is 0, an update leaves the flag at 0.
- R11: Register 0x0A is read-only. Writing 0x80 to it while idle leaves it reading 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 selects the register number, 1 selects the data of that register |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| irq_o | output | 1 | Update-complete interrupt flag |

## Verification
The hardest state to reach from the ports is the middle of a long carry ripple. This is where a read returns seconds already wrapped but minutes not yet advanced, and where a host write must be dropped. The bench loads an end-of-year time in the idle part of a second and polls the status bit until it rises. From that detection edge it counts clock cycles to the exact step enables at which each field is due to change. It reads one field just before its change and a neighbour just after. Each table vector also measures how long the flag stays high, which pins down how many fields the ripple advanced.

// File: rtl/rtc_uip_pkg.sv
package rtc_uip_pkg;

    localparam int NUM_FIELDS = 7;

    // element 0 = seconds ... element 6 = century, each two BCD digits
    typedef logic [NUM_FIELDS-1:0][7:0] rtc_time_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GUARD,
        ST_RIPPLE
    } upd_state_e;

    localparam logic [7:0] IDX_STATUS = 8'h0A;
    localparam logic [7:0] IDX_CTRL   = 8'h0B;
    localparam logic [7:0] IDX_FLAG   = 8'h0C;

    function automatic logic [6:0] bcd_to_bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    function automatic logic [7:0] bin_to_bcd(input logic [6:0] v);
        logic [6:0] tens;
        logic [6:0] ones;
        tens = v / 7'd10;
        ones = v % 7'd10;
        return {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic is_leap(input logic [6:0] yr, input logic [6:0] cen);
        return (yr[1:0] == 2'b00) && ((yr != 7'd0) || (cen[1:0] == 2'b00));
    endfunction

    function automatic logic [6:0] month_days(input logic [6:0] mon, input logic leap);
        logic [6:0] n;
        case (mon)
            7'd2:                      n = leap ? 7'd29 : 7'd28;
            7'd4, 7'd6, 7'd9, 7'd11:   n = 7'd30;
            default:                   n = 7'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
    parameter int CLKS_PER_STEP = 8,
    parameter int STEPS_PER_SEC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic step_tick,
    output logic sec_tick
);
    localparam int PRE_W = $clog2(CLKS_PER_STEP);
    localparam int SUB_W = $clog2(STEPS_PER_SEC);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [SUB_W-1:0] sub;
    } tick_regs_t;

    tick_regs_t tk_q, tk_d;

    always_comb begin
        tk_d      = tk_q;
        step_tick = (tk_q.pre == PRE_W'(CLKS_PER_STEP - 1));
        sec_tick  = step_tick && (tk_q.sub == SUB_W'(STEPS_PER_SEC - 1));
        if (step_tick) begin
            tk_d.pre = '0;
            tk_d.sub = sec_tick ? '0 : tk_q.sub + 1'b1;
        end else begin
            tk_d.pre = tk_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end
endmodule

// File: rtl/rtc_field_inc.sv
module rtc_field_inc
    import rtc_uip_pkg::*;
(
    input  rtc_time_t  tm_i,
    input  logic [2:0] sel_i,
    output logic [7:0] val_o,
    output logic       wrap_o
);
    logic [7:0] fld;
    logic [6:0] cur, lo, hi;
    logic       leap;

    always_comb begin
        fld = '0;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (sel_i == 3'(i)) fld = tm_i[i];
        end
        cur  = bcd_to_bin(fld);
        leap = is_leap(bcd_to_bin(tm_i[5]), bcd_to_bin(tm_i[6]));
        case (sel_i)
            3'd0, 3'd1: begin lo = 7'd0; hi = 7'd59; end
            3'd2:       begin lo = 7'd0; hi = 7'd23; end
            3'd3:       begin lo = 7'd1; hi = month_days(bcd_to_bin(tm_i[4]), leap); end
            3'd4:       begin lo = 7'd1; hi = 7'd12; end
            default:    begin lo = 7'd0; hi = 7'd99; end
        endcase
        wrap_o = (cur >= hi);
        val_o  = wrap_o ? bin_to_bcd(lo) : bin_to_bcd(cur + 7'd1);
    end
endmodule

// File: rtl/rtc_uip_clock.sv
module rtc_uip_clock
    import rtc_uip_pkg::*;
#(
    parameter int CLKS_PER_STEP = 8,
    parameter int STEPS_PER_SEC = 4096,
    parameter int GUARD_STEPS   = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_o
);
    localparam int GRD_W = $clog2(GUARD_STEPS + 1);
    localparam rtc_time_t TM_RESET = {8'h20, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    typedef struct packed {
        upd_state_e       state;
        logic [GRD_W-1:0] guard;
        logic [2:0]       fidx;
        logic             uip;
        logic [7:0]       index;
        rtc_time_t        tm;
        logic             irq_en;
        logic             irq_flag;
    } regs_t;

    localparam regs_t RST_REGS = '{
        state: ST_IDLE, guard: '0, fidx: '0, uip: 1'b0,
        index: '0, tm: TM_RESET, irq_en: 1'b0, irq_flag: 1'b0
    };

    regs_t      q, d;
    logic       step_tick, sec_tick;
    logic [7:0] inc_val;
    logic       inc_wrap;
    logic       in_guard;

    rtc_tick_gen #(
        .CLKS_PER_STEP(CLKS_PER_STEP),
        .STEPS_PER_SEC(STEPS_PER_SEC)
    ) tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_tick(step_tick),
        .sec_tick (sec_tick)
    );

    rtc_field_inc inc_i (
        .tm_i  (q.tm),
        .sel_i (q.fidx),
        .val_o (inc_val),
        .wrap_o(inc_wrap)
    );

    always_comb begin
        d = q;
        if (step_tick) begin
            case (q.state)
                ST_IDLE: if (sec_tick) begin
                    d.state = ST_GUARD;
                    d.uip   = 1'b1;
                    d.guard = GRD_W'(GUARD_STEPS);
                end
                ST_GUARD: begin
                    if (q.guard == GRD_W'(1)) begin
                        d.state = ST_RIPPLE;
                        d.fidx  = '0;
                    end else begin
                        d.guard = q.guard - 1'b1;
                    end
                end
                ST_RIPPLE: begin
                    for (int i = 0; i < NUM_FIELDS; i++) begin
                        if (q.fidx == 3'(i)) d.tm[i] = inc_val;
                    end
                    if (inc_wrap && q.fidx != 3'(NUM_FIELDS - 1)) begin
                        d.fidx = q.fidx + 1'b1;
                    end else begin
                        d.state = ST_IDLE;
                        d.uip   = 1'b0;
                        if (q.irq_en) d.irq_flag = 1'b1;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
        if (bus_we) begin
            if (!bus_addr) begin
                d.index = bus_wdata;
            end else begin
                for (int i = 0; i < NUM_FIELDS; i++) begin
                    if (q.index == 8'(i) && !q.uip) d.tm[i] = bus_wdata;
                end
                if (q.index == IDX_CTRL) d.irq_en   = bus_wdata[0];
                if (q.index == IDX_FLAG) d.irq_flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_REGS;
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr) begin
            bus_rdata = q.index;
        end else begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
                if (q.index == 8'(i)) bus_rdata = q.tm[i];
            end
            if (q.index == IDX_STATUS) bus_rdata = {q.uip, 7'b0};
            if (q.index == IDX_CTRL)   bus_rdata = {7'b0, q.irq_en};
            if (q.index == IDX_FLAG)   bus_rdata = {7'b0, q.irq_flag};
        end
    end

    assign irq_o    = q.irq_flag;
    assign in_guard = (q.state == ST_GUARD);
endmodule

// File: rtl/rtc_uip_clock_sva.sv
module rtc_uip_clock_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        uip,
    input logic        in_guard,
    input logic        step_tick,
    input logic        irq,
    input logic [55:0] tm,
    input logic        bus_addr,
    input logic        bus_we,
    input logic [7:0]  index
);
    logic wr_time;
    assign wr_time = bus_we && bus_addr && (index <= 8'd6);

    AST_UIP_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uip) |-> $past(step_tick)); // R3

    AST_GUARD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_guard && $past(in_guard)) |-> $stable(tm)); // R4

    AST_ONE_FIELD_PER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({tm[55:48] != $past(tm[55:48]), tm[47:40] != $past(tm[47:40]),
                    tm[39:32] != $past(tm[39:32]), tm[31:24] != $past(tm[31:24]),
                    tm[23:16] != $past(tm[23:16]), tm[15:8]  != $past(tm[15:8]),
                    tm[7:0]   != $past(tm[7:0])}) <= 1); // R5

    AST_IDLE_ONLY_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (!uip && !$past(uip) && !$past(wr_time)) |-> $stable(tm)); // R2

    AST_IRQ_AT_UPDATE_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(uip)); // R10
endmodule

bind rtc_uip_clock rtc_uip_clock_sva chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .uip      (q.uip),
    .in_guard (in_guard),
    .step_tick(step_tick),
    .irq      (irq_o),
    .tm       (q.tm),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .index    (q.index)
);

// File: tb/rtc_uip_clock_tb.sv
`timescale 1ns/1ps
module rtc_uip_clock_tb_top;
    localparam int DIV   = 4;
    localparam int STEPS = 32;
    localparam int GUARD = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    rtc_uip_clock #(
        .CLKS_PER_STEP(DIV),
        .STEPS_PER_SEC(STEPS),
        .GUARD_STEPS  (GUARD)
    ) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    // {start time, expected time, fields advanced}; time = {cen,yr,mon,day,hr,min,sec}
    localparam int NVEC = 12;
    localparam logic [119:0] VECS [NVEC] = '{
        {56'h20_24_03_15_10_20_30, 56'h20_24_03_15_10_20_31, 8'd1},
        {56'h20_24_03_15_10_20_59, 56'h20_24_03_15_10_21_00, 8'd2},
        {56'h20_24_03_15_10_59_59, 56'h20_24_03_15_11_00_00, 8'd3},
        {56'h20_24_03_15_23_59_59, 56'h20_24_03_16_00_00_00, 8'd4},
        {56'h20_23_02_28_23_59_59, 56'h20_23_03_01_00_00_00, 8'd5},
        {56'h20_24_02_28_23_59_59, 56'h20_24_02_29_00_00_00, 8'd4},
        {56'h20_24_02_29_23_59_59, 56'h20_24_03_01_00_00_00, 8'd5},
        {56'h20_24_04_30_23_59_59, 56'h20_24_05_01_00_00_00, 8'd5},
        {56'h19_99_12_31_23_59_59, 56'h20_00_01_01_00_00_00, 8'd7},
        {56'h19_00_02_28_23_59_59, 56'h19_00_03_01_00_00_00, 8'd5},
        {56'h20_00_02_28_23_59_59, 56'h20_00_02_29_00_00_00, 8'd4},
        {56'h20_24_01_31_23_59_59, 56'h20_24_02_01_00_00_00, 8'd5}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
        bus_write(1'b0, idx);
        bus_addr = 1'b1;
        #1 v = bus_rdata;
    endtask

    task automatic read_time(output logic [55:0] t);
        logic [7:0] b;
        for (int i = 0; i < 7; i++) begin
            read_reg(8'(i), b);
            t[i*8 +: 8] = b;
        end
    endtask

    task automatic set_time(input logic [55:0] t);
        for (int i = 0; i < 7; i++) begin
            bus_write(1'b0, 8'(i));
            bus_write(1'b1, t[i*8 +: 8]);
        end
    endtask

    // poll status until its flag equals lvl; returns negedges waited
    task automatic wait_uip(input logic lvl, output int n);
        logic [7:0] b;
        read_reg(8'h0A, b);
        n = 0;
        while (b[7] !== lvl) begin
            @(negedge clk);
            #1 b = bus_rdata;
            n++;
        end
    endtask

    initial begin
        int n;
        logic [7:0]  b;
        logic [55:0] t;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_time(t);
        check("R1 time", 64'(t), 64'h20_00_01_01_00_00_00);
        read_reg(8'h0A, b);  check("R1 status", 64'(b), 64'h00);
        read_reg(8'h0B, b);  check("R1 ctrl", 64'(b), 64'h00);
        check("R1 irq_o", 64'(irq_o), 64'h0);

        // R2 index readback, field write, unmapped read
        bus_write(1'b0, 8'h05);
        bus_addr = 1'b0; #1 check("R2 index readback", 64'(bus_rdata), 64'h05);
        bus_write(1'b1, 8'h42);
        read_reg(8'h05, b);  check("R2 field write", 64'(b), 64'h42);
        read_reg(8'h20, b);  check("R2 unmapped", 64'(b), 64'h00);

        wait_uip(1'b1, n);
        wait_uip(1'b0, n);

        // table walk: R5 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            set_time(VECS[v][119:64]);
            wait_uip(1'b1, n);
            n = 0;
            do begin
                @(negedge clk);
                #1 n++;
            end while (bus_rdata[7]);
            check($sformatf("R5 flag length vec%0d", v), 64'(n),
                  64'((GUARD + int'(VECS[v][7:0])) * DIV));
            read_time(t);
            check($sformatf("R7/R8 time vec%0d", v), 64'(t), 64'(VECS[v][63:8]));
        end

        // R3 period between update starts
        wait_uip(1'b1, n);
        n = 0;
        do begin @(negedge clk); #1 n++; end while (bus_rdata[7]);
        do begin @(negedge clk); #1 n++; end while (!bus_rdata[7]);
        check("R3 period", 64'(n), 64'(STEPS * DIV));

        // R4 guard and R6 torn read
        wait_uip(1'b0, n);
        set_time(56'h19_99_12_31_23_59_59);
        wait_uip(1'b1, n);                 // at N0
        bus_write(1'b0, 8'h00);            // ends at N0+2
        bus_addr = 1'b1;
        #1 check("R4 seconds frozen in guard", 64'(bus_rdata), 64'h59);
        repeat ((GUARD + 1) * DIV - 2) @(negedge clk);   // N0+12
        #1 check("R6 seconds advanced", 64'(bus_rdata), 64'h00);
        bus_write(1'b0, 8'h01);            // ends at N0+14
        bus_addr = 1'b1;
        #1 check("R6 minutes still old", 64'(bus_rdata), 64'h59);
        repeat (2) @(negedge clk);         // N0+16
        #1 check("R6 minutes advanced", 64'(bus_rdata), 64'h00);

        // R9 write during update dropped
        wait_uip(1'b0, n);
        set_time(56'h20_24_06_10_08_30_10);
        wait_uip(1'b1, n);
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h45);
        wait_uip(1'b0, n);
        read_reg(8'h00, b);
        check("R9 write ignored", 64'(b), 64'h11);

        // R11 status read-only
        bus_write(1'b0, 8'h0A);
        bus_write(1'b1, 8'h80);
        read_reg(8'h0A, b);
        check("R11 status read-only", 64'(b), 64'h00);

        // R10 interrupt
        bus_write(1'b0, 8'h0B);
        bus_write(1'b1, 8'h01);
        wait_uip(1'b1, n);
        wait_uip(1'b0, n);
        check("R10 irq set", 64'(irq_o), 64'h1);
        read_reg(8'h0C, b);
        check("R10 flag reg", 64'(b), 64'h01);
        bus_write(1'b1, 8'h00);
        #1 check("R10 irq cleared", 64'(irq_o), 64'h0);
        bus_write(1'b0, 8'h0B);
        bus_write(1'b1, 8'h00);
        wait_uip(1'b1, n);
        wait_uip(1'b0, n);
        check("R10 irq disabled", 64'(irq_o), 64'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule